// File: doc/BRIEF.md
# Management-controller byte-handshake sequencer

This block is the host side of a byte-wide mailbox to a management controller. The controller is reached through a window of three byte registers: data at offset 0, control/status at offset 1 and flags at offset 2. Software first fills a request buffer of up to 80 bytes. It then pulses `start` with the request length. The sequencer works through a fixed chain of states: a readiness probe, a write phase that pushes the request bytes, and a read phase that pulls the response into a second 80-byte buffer. It finishes by reporting completion, attention or failure on a one-hot result output.

Each step has the same shape. The sequencer evaluates the flags and status while the far side is not busy. It writes a control code, optionally writes a data byte, and then writes the flags back with the busy bit set. That last write hands the step to the far side. If the sequencer sees an unexpected status, a nonzero error byte or an expired time budget, it restarts the whole exchange from the probe. After too many restarts it gives up through a failed state.

States, in order: IDLE, START (issue probe), OPOK (probe answered ready, issue write-start with byte 0), WSTART and WNEXT (send further bytes), WEND (check write error byte), W2R (wait for receive data), RSTART and RNEXT (collect bytes), REND (check read error byte), HOSED (failed, leaves to IDLE on the next step). Transitions: a step issue moves to the planned next state; a recovery moves to START or HOSED; an accepted start moves to START.

Top module: `mgmt_byte_host`

## Requirements
- R1: A `start` pulse is refused, with `start_rej` high on the following cycle and nothing else changing, when `start_len` is below 2, above 80, or while a transaction is running; otherwise it is accepted in IDLE or HOSED.
- R2: While flag bit 0 (busy) reads 1, the sequencer starts no window write and reports no attention.
- R3: Each step writes offset 1 (control), then optionally offset 0 (data), then offset 2 (flags) with bit 0 set, one write per cycle.
- R4: A clean exchange issues control codes 0x40 (probe), 0x41 (write start), 0x42 (write next) for each middle byte, 0x43 (write end), 0x44 (read start), 0x45 (read next) per further byte, then 0x46 (read end); the expected status for each is the code with bit 7 set, with 0xC0 meaning ready.
- R5: Request bytes go out in buffer order, the first with 0x41 and the last with 0x43. A 0x42 or 0x43 is issued only while flag bit 6 (transmit ready) is 1.
- R6: A status other than the expected one triggers recovery. So does a nonzero data byte when the sequencer checks after write end (status 0xC3) or after read end (status 0xC0). In the read phase, status 0xC6 takes the last byte and issues read end; status 0xC5 together with flag bit 7 (receive ready) takes one more byte.
- R7: Recovery restarts from the probe with the original length. The fourth recovery of one exchange enters HOSED instead, which reports failure on the next cycle and returns to IDLE.
- R8: A budget of TIMEOUT counts, reloaded on every step and every recovery, is decremented once per cycle with `tick` high while the sequencer waits. It expires after TIMEOUT+1 counts and then triggers recovery.
- R9: Response bytes are stored in arrival order and counted in `rsp_count`. Bytes past the 80th are discarded and `rsp_trunc` is set.
- R10: `result` is one-hot: bit 0 completion, bit 1 attention, bit 2 failure. It is cleared by an accepted start and otherwise held.
- R11: In IDLE with busy clear and no result held, any of flag bits 4, 3 or 2 sets the attention result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request pulse |
| start_len | input | 7 | Request length in bytes |
| req_we | input | 1 | Request buffer write enable |
| req_addr | input | 7 | Request buffer byte index |
| req_data | input | 8 | Request buffer byte |
| tick | input | 1 | Time-budget decrement enable |
| win_flags | input | 8 | Window flags register value |
| win_status | input | 8 | Window status register value |
| win_data | input | 8 | Window data register value |
| win_we | output | 1 | Window write strobe |
| win_addr | output | 2 | Window register offset |
| win_wdata | output | 8 | Window write byte |
| start_rej | output | 1 | Start refused (one cycle) |
| result | output | 3 | One-hot outcome {failure, attention, completion} |
| rsp_addr | input | 7 | Response buffer read index |
| rsp_data | output | 8 | Response byte at `rsp_addr` |
| rsp_count | output | 7 | Stored response bytes |
| rsp_trunc | output | 1 | Response was longer than the buffer |

## Verification
The properties assume that the far side raises busy only after the sequencer's flags write and keeps the window registers steady while a step's writes are in flight. They also assume that `start` is not pulsed in the cycle a result is produced. The bench's register-window model changes flags, status and data only when it answers a handed-over step, after a fixed delay, or when a scenario deliberately holds busy or raises attention. Each scenario also waits for the result before it issues the next start.

// File: rtl/mbh_pkg.sv
package mbh_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_START, S_OPOK, S_WSTART, S_WNEXT, S_WEND,
        S_W2R, S_RSTART, S_RNEXT, S_REND, S_HOSED
    } seq_state_t;

    typedef enum logic [1:0] {PH_EVAL, PH_CTRL, PH_DATA, PH_FLAG} phase_t;

    localparam logic [7:0] CC_PROBE  = 8'h40;
    localparam logic [7:0] CC_WSTART = 8'h41;
    localparam logic [7:0] CC_WNEXT  = 8'h42;
    localparam logic [7:0] CC_WEND   = 8'h43;
    localparam logic [7:0] CC_RSTART = 8'h44;
    localparam logic [7:0] CC_RNEXT  = 8'h45;
    localparam logic [7:0] CC_REND   = 8'h46;
    localparam logic [7:0] ST_BIT    = 8'h80;

    localparam int F_BUSY = 0;
    localparam int F_TXR  = 6;
    localparam int F_RXR  = 7;
    localparam logic [7:0] ATTN_MASK = 8'h1C;

    localparam logic [1:0] OFS_DATA = 2'd0;
    localparam logic [1:0] OFS_CTRL = 2'd1;
    localparam logic [1:0] OFS_FLAG = 2'd2;

    localparam int RES_DONE  = 0;
    localparam int RES_ATTN  = 1;
    localparam int RES_HOSED = 2;
endpackage

// File: rtl/mbh_byte_buf.sv
module mbh_byte_buf #(
    parameter int DEPTH = 80,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;
endmodule

// File: rtl/mbh_budget.sv
module mbh_budget #(
    parameter int LIMIT = 100000,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic run,
    output logic expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= W'(LIMIT);
        else if (reload)            cnt <= W'(LIMIT);
        else if (run && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = run && (cnt == '0);
endmodule

// File: rtl/mgmt_byte_host.sv
module mgmt_byte_host
    import mbh_pkg::*;
#(
    parameter int BUF_BYTES   = 80,
    parameter int MAX_RETRIES = 3,
    parameter int TIMEOUT     = 100000,
    localparam int AW = $clog2(BUF_BYTES),
    localparam int LW = $clog2(BUF_BYTES + 1),
    localparam int RW = $clog2(MAX_RETRIES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] start_len,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          tick,
    input  logic [7:0]    win_flags,
    input  logic [7:0]    win_status,
    input  logic [7:0]    win_data,
    output logic          win_we,
    output logic [1:0]    win_addr,
    output logic [7:0]    win_wdata,
    output logic          start_rej,
    output logic [2:0]    result,
    input  logic [AW-1:0] rsp_addr,
    output logic [7:0]    rsp_data,
    output logic [LW-1:0] rsp_count,
    output logic          rsp_trunc
);
    seq_state_t state, nstate_q, ev_next;
    phase_t     phase;

    logic [LW-1:0] wlen, wpos;
    logic [RW-1:0] retries;
    logic [7:0]    ctrl_q, data_q, flags_q, req_rdata, ev_ctrl;
    logic          has_data;
    logic ev_issue, ev_jump, ev_recover, ev_take, ev_done, ev_attn, ev_exit, ev_data;
    logic accept, len_ok, t_expired, t_run, t_reload, last_byte, rsp_we;

    assign len_ok    = (start_len >= LW'(2)) && (start_len <= LW'(BUF_BYTES));
    assign accept    = start && len_ok && phase == PH_EVAL &&
                       (state == S_IDLE || state == S_HOSED);
    assign last_byte = (wlen - wpos) == LW'(1);

    mbh_byte_buf #(.DEPTH(BUF_BYTES)) u_req (
        .clk(clk), .we(req_we), .waddr(req_addr), .wdata(req_data),
        .raddr(AW'(wpos)), .rdata(req_rdata));

    assign rsp_we = ev_take && (rsp_count < LW'(BUF_BYTES));
    mbh_byte_buf #(.DEPTH(BUF_BYTES)) u_rsp (
        .clk(clk), .we(rsp_we), .waddr(AW'(rsp_count)), .wdata(win_data),
        .raddr(rsp_addr), .rdata(rsp_data));

    assign t_run    = tick && phase == PH_EVAL && state != S_IDLE && state != S_HOSED;
    assign t_reload = accept || ev_issue || ev_jump || ev_recover;
    mbh_budget #(.LIMIT(TIMEOUT)) u_budget (
        .clk(clk), .rst_n(rst_n), .reload(t_reload), .run(t_run), .expired(t_expired));

    // Step evaluation: decides what the current state does with the window view.
    always_comb begin
        ev_issue = 1'b0; ev_jump = 1'b0; ev_recover = 1'b0; ev_take = 1'b0;
        ev_done = 1'b0; ev_attn = 1'b0; ev_exit = 1'b0; ev_data = 1'b0;
        ev_ctrl = CC_PROBE; ev_next = state;
        if (phase == PH_EVAL && !accept) begin
            if (state == S_HOSED) begin
                ev_exit = 1'b1;
            end else if (t_expired) begin
                ev_recover = 1'b1;
            end else if (!win_flags[F_BUSY]) begin
                unique case (state)
                    S_IDLE:  ev_attn = |(win_flags & ATTN_MASK);
                    S_START: begin ev_issue = 1'b1; ev_next = S_OPOK; end
                    S_OPOK:
                        if (win_status != (CC_PROBE | ST_BIT)) ev_recover = 1'b1;
                        else begin
                            ev_issue = 1'b1; ev_data = 1'b1;
                            ev_ctrl = CC_WSTART; ev_next = S_WSTART;
                        end
                    S_WSTART, S_WNEXT:
                        if (win_status != (((state == S_WSTART) ? CC_WSTART : CC_WNEXT) | ST_BIT))
                            ev_recover = 1'b1;
                        else if (win_flags[F_TXR]) begin
                            ev_issue = 1'b1; ev_data = 1'b1;
                            ev_ctrl  = last_byte ? CC_WEND : CC_WNEXT;
                            ev_next  = last_byte ? S_WEND : S_WNEXT;
                        end
                    S_WEND:
                        if (win_status != (CC_WEND | ST_BIT) || win_data != 8'h00) ev_recover = 1'b1;
                        else begin ev_jump = 1'b1; ev_next = S_W2R; end
                    S_W2R:
                        if (win_flags[F_RXR]) begin
                            ev_issue = 1'b1; ev_ctrl = CC_RSTART; ev_next = S_RSTART;
                        end
                    S_RSTART:
                        if (win_status != (CC_RSTART | ST_BIT)) ev_recover = 1'b1;
                        else if (win_flags[F_RXR]) begin
                            ev_issue = 1'b1; ev_take = 1'b1;
                            ev_ctrl = CC_RNEXT; ev_next = S_RNEXT;
                        end
                    S_RNEXT:
                        if (win_status == (CC_REND | ST_BIT)) begin
                            ev_issue = 1'b1; ev_take = 1'b1;
                            ev_ctrl = CC_REND; ev_next = S_REND;
                        end else if (win_status == (CC_RNEXT | ST_BIT)) begin
                            if (win_flags[F_RXR]) begin
                                ev_issue = 1'b1; ev_take = 1'b1;
                                ev_ctrl = CC_RNEXT; ev_next = S_RNEXT;
                            end
                        end else ev_recover = 1'b1;
                    S_REND:
                        if (win_status != (CC_PROBE | ST_BIT) || win_data != 8'h00) ev_recover = 1'b1;
                        else begin ev_jump = 1'b1; ev_done = 1'b1; ev_next = S_IDLE; end
                    default: ev_recover = 1'b1;
                endcase
            end
        end
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            phase <= PH_EVAL;
            nstate_q <= S_IDLE;
        end else if (accept) begin
            state <= S_START;
            phase <= PH_EVAL;
        end else begin
            unique case (phase)
                PH_EVAL:
                    if (ev_exit) state <= S_IDLE;
                    else if (ev_recover)
                        state <= (retries == RW'(MAX_RETRIES)) ? S_HOSED : S_START;
                    else if (ev_issue) begin
                        nstate_q <= ev_next;
                        phase    <= PH_CTRL;
                    end else if (ev_jump) state <= ev_next;
                PH_CTRL: phase <= has_data ? PH_DATA : PH_FLAG;
                PH_DATA: phase <= PH_FLAG;
                PH_FLAG: begin
                    phase <= PH_EVAL;
                    state <= nstate_q;
                end
                default: phase <= PH_EVAL;
            endcase
        end
    end

    // Datapath and output process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wlen <= '0; wpos <= '0; retries <= '0; rsp_count <= '0; rsp_trunc <= 1'b0;
            ctrl_q <= '0; data_q <= '0; flags_q <= '0; has_data <= 1'b0;
            result <= '0; start_rej <= 1'b0;
        end else begin
            start_rej <= start && !accept;
            if (accept) begin
                wlen <= start_len; wpos <= '0; retries <= '0;
                rsp_count <= '0; rsp_trunc <= 1'b0; result <= '0;
            end else if (ev_exit) begin
                result <= 3'b001 << RES_HOSED;
            end else if (ev_recover) begin
                if (retries != RW'(MAX_RETRIES)) retries <= retries + 1'b1;
                wpos <= '0; rsp_count <= '0; rsp_trunc <= 1'b0;
            end else if (ev_issue) begin
                ctrl_q   <= ev_ctrl;
                data_q   <= req_rdata;
                has_data <= ev_data;
                flags_q  <= win_flags | 8'h01;
                if (ev_data) wpos <= wpos + 1'b1;
                if (ev_take) begin
                    if (rsp_we) rsp_count <= rsp_count + 1'b1;
                    else        rsp_trunc <= 1'b1;
                end
            end else if (ev_done) begin
                result <= 3'b001 << RES_DONE;
            end else if (ev_attn && result == '0) begin
                result <= 3'b001 << RES_ATTN;
            end
        end
    end

    always_comb begin
        win_we = (phase != PH_EVAL);
        unique case (phase)
            PH_CTRL: begin win_addr = OFS_CTRL; win_wdata = ctrl_q;  end
            PH_DATA: begin win_addr = OFS_DATA; win_wdata = data_q;  end
            PH_FLAG: begin win_addr = OFS_FLAG; win_wdata = flags_q; end
            default: begin win_addr = OFS_DATA; win_wdata = 8'h00;   end
        endcase
    end
endmodule

// File: rtl/mgmt_byte_host_chk.sv
module mgmt_byte_host_chk #(
    parameter int BUF_BYTES = 80,
    localparam int LW = $clog2(BUF_BYTES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [LW-1:0] start_len,
    input logic [7:0]    win_flags,
    input logic          win_we,
    input logic [1:0]    win_addr,
    input logic [7:0]    win_wdata,
    input logic          start_rej,
    input logic [2:0]    result,
    input logic [LW-1:0] rsp_count,
    input logic          rsp_trunc
);
    p_len_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start && (start_len < LW'(2) || start_len > LW'(BUF_BYTES)) |=> start_rej);

    p_busy_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_we && win_flags[0]) |=> !win_we);

    p_ctrl_then_more_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && win_addr == 2'd1) |=> (win_we && win_addr != 2'd1));

    p_flag_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && win_addr == 2'd2) |-> win_wdata[0]);

    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_count <= LW'(BUF_BYTES));

    p_trunc_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trunc |-> rsp_count == LW'(BUF_BYTES));

    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(result));

    p_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (result != 3'b000 && !start) |=> $stable(result));
endmodule

bind mgmt_byte_host mgmt_byte_host_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
    .win_flags(win_flags), .win_we(win_we), .win_addr(win_addr),
    .win_wdata(win_wdata), .start_rej(start_rej), .result(result),
    .rsp_count(rsp_count), .rsp_trunc(rsp_trunc));

// File: tb/mgmt_byte_host_bench.sv
module mgmt_byte_host_bench;
    localparam int BUF = 80;
    localparam int TO  = 30;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, req_we = 1'b0, tick = 1'b1;
    logic [6:0] start_len = '0, req_addr = '0, rsp_addr = '0, rsp_count;
    logic [7:0] req_data = '0, win_flags, win_status, win_data, win_wdata, rsp_data;
    logic       win_we, start_rej, rsp_trunc;
    logic [1:0] win_addr;
    logic [2:0] result;

    always #10 clk = ~clk;

    mgmt_byte_host #(.BUF_BYTES(BUF), .MAX_RETRIES(3), .TIMEOUT(TO)) u_mgmt_byte_host (
        .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
        .req_we(req_we), .req_addr(req_addr), .req_data(req_data), .tick(tick),
        .win_flags(win_flags), .win_status(win_status), .win_data(win_data),
        .win_we(win_we), .win_addr(win_addr), .win_wdata(win_wdata),
        .start_rej(start_rej), .result(result), .rsp_addr(rsp_addr),
        .rsp_data(rsp_data), .rsp_count(rsp_count), .rsp_trunc(rsp_trunc));

    function automatic logic [7:0] req_byte(int k); return 8'(k * 29 + 1); endfunction
    function automatic logic [7:0] rsp_byte(int k); return 8'(k * 13 + 5); endfunction

    // Scenario knobs, written only by the bench tasks.
    logic stuck = 1'b0;
    logic [2:0] attn = '0;
    int cfg_rlen = 4, cfg_txd = 0, werr_limit = 0, bad_limit = 0;

    // Far-side model state, written only by the model process.
    logic m_busy, m_tx, m_rx, in_step;
    logic [7:0] m_status, m_data, m_ctrl;
    int m_cd, m_txcd, ridx, werr_used, bad_used, tx_viol, ord_viol;
    int ctrl_n, data_n;
    logic [7:0] ctrl_log [0:1023];
    logic [7:0] data_log [0:1023];

    assign win_flags  = {m_rx, m_tx, 1'b0, attn, 1'b0, m_busy | stuck};
    assign win_status = m_status;
    assign win_data   = m_data;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_tx = 0; m_rx = 0; in_step = 0; m_status = 8'hC0; m_data = 0;
            m_ctrl = 0; m_cd = 0; m_txcd = 0; ridx = 0; werr_used = 0; bad_used = 0;
            tx_viol = 0; ord_viol = 0; ctrl_n = 0; data_n = 0;
        end else begin
            if (m_txcd > 0) begin m_txcd--; if (m_txcd == 0) m_tx = 1; end
            if (m_cd > 0) begin
                m_cd--;
                if (m_cd == 0) begin
                    m_busy = 0;
                    case (m_ctrl)
                        8'h40: begin m_status = 8'hC0; m_data = 8'h00; end
                        8'h41, 8'h42: begin
                            m_status = m_ctrl | 8'h80;
                            if (cfg_txd == 0) m_tx = 1; else begin m_tx = 0; m_txcd = cfg_txd; end
                        end
                        8'h43: begin
                            m_status = 8'hC3; m_rx = 1;
                            if (werr_used < werr_limit) begin m_data = 8'h05; werr_used++; end
                            else m_data = 8'h00;
                        end
                        8'h44: begin ridx = 0; m_status = 8'hC4; m_data = rsp_byte(0); m_rx = 1; end
                        8'h45: begin
                            ridx++; m_data = rsp_byte(ridx);
                            if (bad_used < bad_limit) begin m_status = 8'hC9; bad_used++; end
                            else m_status = (ridx == cfg_rlen - 1) ? 8'hC6 : 8'hC5;
                        end
                        8'h46: begin m_status = 8'hC0; m_data = 8'h00; m_rx = 0; end
                        default: m_status = 8'hC0;
                    endcase
                end
            end
            if (win_we) begin
                case (win_addr)
                    2'd1: begin
                        if (in_step) ord_viol++;
                        in_step = 1; m_ctrl = win_wdata;
                        ctrl_log[ctrl_n % 1024] = win_wdata; ctrl_n++;
                        if ((win_wdata == 8'h42 || win_wdata == 8'h43) && !m_tx) tx_viol++;
                    end
                    2'd0: begin
                        if (!in_step) ord_viol++;
                        data_log[data_n % 1024] = win_wdata; data_n++;
                    end
                    default: begin
                        if (!in_step || !win_wdata[0]) ord_viol++;
                        in_step = 0; m_busy = 1; m_cd = 3;
                    end
                endcase
            end
        end
    end

    int checks = 0, fails = 0;
    logic finished = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_req(input int len);
        for (int k = 0; k < len; k++) begin
            req_we = 1; req_addr = 7'(k); req_data = req_byte(k); @(negedge clk);
        end
        req_we = 0;
    endtask

    task automatic pulse_start(input int len);
        start_len = 7'(len); start = 1; @(negedge clk); start = 0;
    endtask

    task automatic wait_result(input int limit);
        for (int i = 0; i < limit && result == 3'b000; i++) @(negedge clk);
    endtask

    task automatic count_gets(input int base, output int n);
        n = 0;
        for (int i = base; i < ctrl_n; i++) if (ctrl_log[i % 1024] == 8'h40) n++;
    endtask

    task automatic t_reset;
        rst_n = 0; cycles(4); rst_n = 1; cycles(2);
        chk("R10 reset result", result, 0);
        chk("R3 reset no write", win_we, 0);
        chk("R9 reset count", rsp_count, 0);
        chk("R9 reset trunc", rsp_trunc, 0);
        chk("R1 reset reject", start_rej, 0);
    endtask

    task automatic t_attention;
        stuck = 1; attn = 3'b010; cycles(10);
        chk("R2 attention masked by busy", result, 0);
        stuck = 0; cycles(3);
        chk("R11 attention reported", result, 3'b010);
        attn = 3'b000; cycles(5);
        chk("R10 attention held", result, 3'b010);
    endtask

    task automatic t_reject_and_basic;
        int cb, db, exp_ctrl [11];
        exp_ctrl = '{8'h40, 8'h41, 8'h42, 8'h42, 8'h43, 8'h44, 8'h45, 8'h45, 8'h45, 8'h45, 8'h46};
        load_req(4); cfg_rlen = 5;
        pulse_start(1);
        chk("R1 reject short", start_rej, 1);
        chk("R1 short leaves result", result, 3'b010);
        pulse_start(81);
        chk("R1 reject long", start_rej, 1);
        cb = ctrl_n; db = data_n;
        pulse_start(4);
        chk("R1 accept", start_rej, 0);
        chk("R10 cleared by accept", result, 0);
        cycles(2); pulse_start(4);
        chk("R1 reject while running", start_rej, 1);
        wait_result(2000);
        chk("R10 completion", result, 3'b001);
        chk("R4 control count", ctrl_n - cb, 11);
        for (int i = 0; i < 11; i++) chk("R4 control code", ctrl_log[(cb + i) % 1024], exp_ctrl[i]);
        chk("R5 byte count", data_n - db, 4);
        for (int i = 0; i < 4; i++) chk("R5 byte order", data_log[(db + i) % 1024], req_byte(i));
        chk("R3 write order", ord_viol, 0);
        chk("R9 count", rsp_count, 5);
        chk("R9 no trunc", rsp_trunc, 0);
        for (int i = 0; i < 5; i++) begin
            rsp_addr = 7'(i); #1; chk("R9 stored byte", rsp_data, rsp_byte(i));
        end
    endtask

    task automatic t_tx_gate;
        int db;
        load_req(3); cfg_rlen = 2; cfg_txd = 6; db = data_n;
        pulse_start(3); wait_result(2000);
        chk("R5 tx gate completion", result, 3'b001);
        chk("R5 no write-next without tx ready", tx_viol, 0);
        for (int i = 0; i < 3; i++) chk("R5 gated byte", data_log[(db + i) % 1024], req_byte(i));
        cfg_txd = 0;
    endtask

    task automatic t_write_error;
        int cb, g, db;
        load_req(2); cfg_rlen = 3; werr_limit = werr_used + 1; cb = ctrl_n; db = data_n;
        pulse_start(2); wait_result(3000);
        count_gets(cb, g);
        chk("R6 write error retried", g, 2);
        chk("R6 retry completes", result, 3'b001);
        chk("R7 original length resent", data_n - db, 4);
        chk("R7 retry first byte", data_log[(db + 2) % 1024], req_byte(0));
    endtask

    task automatic t_bad_status(input int n, input int exp_res);
        int cb, g;
        load_req(2); cfg_rlen = 4; bad_limit = bad_used + n; cb = ctrl_n;
        pulse_start(2); wait_result(5000);
        count_gets(cb, g);
        chk("R7 attempts", g, 4);
        chk("R6 bad status outcome", result, exp_res);
    endtask

    task automatic t_timeout;
        int cb, g, at;
        cb = ctrl_n; stuck = 1; at = 0;
        pulse_start(2);
        for (int i = 2; i < 400 && at == 0; i++) begin
            @(negedge clk); if (result != 3'b000) at = i;
        end
        count_gets(cb, g);
        chk("R8 failure after budget", result, 3'b100);
        chk("R8 cycles to failure", at, 4 * (TO + 1) + 2);
        chk("R2 no writes while busy", g, 0);
        stuck = 0; cycles(2);
        chk("R7 back to idle, held", result, 3'b100);
    endtask

    task automatic t_truncate;
        load_req(2); cfg_rlen = 83;
        pulse_start(2); wait_result(5000);
        chk("R9 long completes", result, 3'b001);
        chk("R9 count capped", rsp_count, BUF);
        chk("R9 trunc set", rsp_trunc, 1);
        rsp_addr = 7'(BUF - 1); #1;
        chk("R9 last kept byte", rsp_data, rsp_byte(BUF - 1));
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_attention();
        t_reject_and_basic();
        t_tx_gate();
        t_write_error();
        t_bad_status(3, 3'b001);
        t_bad_status(4, 3'b100);
        t_timeout();
        t_truncate();
        finished = 1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end
endmodule